// File: doc/BRIEF.md
# Dual-Set Blink Pattern Generator for General-Purpose Pins

This block drives a bank of general-purpose pins from a small register file. Every line has a static output value and a direction bit; the output enable at the pad is simply the inverse of that direction bit, so a line marked as input is never driven.

On top of the static value, each line can be switched to a hardware blink. Two shared timing sets, A and B, each hold an on-length and an off-length in clock cycles. A per-line select bit picks the set. A per-line blink bit replaces the static value at the pad with that set's square wave.

Two command addresses turn a group of lines into driven outputs in one write. The write clears their blink bits, loads their output value and switches them to output, all at the same clock edge.

Top module: `gbl_blink_top`

Register word addresses on `reg_addr_i`:

| Address | Register |
|---|---|
| 0 | output value |
| 1 | direction (1 = input) |
| 2 | blink enable |
| 3 | set select (0 = A, 1 = B) |
| 4 | set A on-length |
| 5 | set A off-length |
| 6 | set B on-length |
| 7 | set B off-length |
| 8 | drive-low command |
| 9 | drive-high command |

## Requirements
- R1: After reset the output value, blink enable and set select registers are 0, the direction register is all ones, and both `pad_oe_o` and `pad_o` are all zeros.
- R2: Bit i of `pad_oe_o` is always the inverse of bit i of the direction register (address 1), where a direction bit of 1 means input.
- R3: A line whose blink bit (address 2) is 0 shows its bit of the output value register (address 0) on `pad_o`, from the cycle after the write.
- R4: A line whose blink bit is 1 shows the wave of set A when its select bit (address 3) is 0, and the wave of set B when it is 1.
- R5: A set's wave is high for on-length cycles, then low for off-length cycles, and repeats. It starts high in the cycle right after the write that makes the set active.
- R6: An on-length or off-length of 0 behaves exactly like a length of 1.
- R7: A length written while its set is running does not shorten or stretch the phase in progress. It first applies to the phase that starts at the next phase boundary.
- R8: A set is active only while at least one line with its blink bit set selects it. An inactive set restarts at the start of its high phase when it becomes active again.
- R9: Writing mask M to address 9 (or address 8) does three things for every line set in M, at the same edge: it clears the line's blink bit, sets (or clears) its output value bit, and clears its direction bit. Lines outside M are left unchanged.
- R10: Registers at addresses 0 to 7 read back the last value written. Addresses 8 and 9 read as 0.
- R11: A line in input mode does not drive its pad even when its blink bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| pad_o | output | 32 | Pad output value per line |
| pad_oe_o | output | 32 | Pad output enable per line |

## Verification
Directed waves use different on and off lengths for the two sets on neighbouring lines. A wrong set selection or a swapped phase therefore shows up as a mismatch within the first period.

Zero lengths separate the treat-as-one rule from a zero-length or wrapped count. A mid-phase length change separates boundary-aligned loading from immediate loading, because the current high phase would be cut short.

Random rounds mix random lengths, select masks, direction masks and blink masks on both sets started together. Random static rounds check the output value and enable paths with blinking off.

// File: rtl/gbl_pkg.sv
package gbl_pkg;
  localparam int unsigned N_SETS = 2;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_OUT    = 4'd0,
    RA_DIR    = 4'd1,
    RA_BLINK  = 4'd2,
    RA_SEL    = 4'd3,
    RA_A_ON   = 4'd4,
    RA_A_OFF  = 4'd5,
    RA_B_ON   = 4'd6,
    RA_B_OFF  = 4'd7,
    RA_DRV_LO = 4'd8,
    RA_DRV_HI = 4'd9
  } reg_addr_e;
endpackage

// File: rtl/gbl_regs.sv
module gbl_regs
  import gbl_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [DW-1:0]               rdata_o,
  output logic [DW-1:0]               out_q,
  output logic [DW-1:0]               dir_q,
  output logic [DW-1:0]               blink_q,
  output logic [DW-1:0]               sel_q,
  output logic [N_SETS-1:0][DW-1:0]   on_q,
  output logic [N_SETS-1:0][DW-1:0]   off_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      sel_q   <= '0;
      on_q    <= '0;
      off_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_OUT:   out_q    <= wdata_i;
        RA_DIR:   dir_q    <= wdata_i;
        RA_BLINK: blink_q  <= wdata_i;
        RA_SEL:   sel_q    <= wdata_i;
        RA_A_ON:  on_q[0]  <= wdata_i;
        RA_A_OFF: off_q[0] <= wdata_i;
        RA_B_ON:  on_q[1]  <= wdata_i;
        RA_B_OFF: off_q[1] <= wdata_i;
        // claim lines as outputs in one edge: no blink, value loaded, driver on
        RA_DRV_LO: begin
          blink_q <= blink_q & ~wdata_i;
          out_q   <= out_q & ~wdata_i;
          dir_q   <= dir_q & ~wdata_i;
        end
        RA_DRV_HI: begin
          blink_q <= blink_q & ~wdata_i;
          out_q   <= out_q | wdata_i;
          dir_q   <= dir_q & ~wdata_i;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RA_OUT:   rdata_o = out_q;
      RA_DIR:   rdata_o = dir_q;
      RA_BLINK: rdata_o = blink_q;
      RA_SEL:   rdata_o = sel_q;
      RA_A_ON:  rdata_o = on_q[0];
      RA_A_OFF: rdata_o = off_q[0];
      RA_B_ON:  rdata_o = on_q[1];
      RA_B_OFF: rdata_o = off_q[1];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gbl_phase.sv
module gbl_phase #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic [CW-1:0] on_len_i,
  input  logic [CW-1:0] off_len_i,
  output logic          wave_o
);
  logic [CW-1:0] on_sh_q, off_sh_q, cnt_q, len_cur;
  logic          ph_q, last;

  assign len_cur = ph_q ? on_sh_q : off_sh_q;
  // zero length ends the phase after one cycle, same as one
  assign last    = (len_cur == '0) || (cnt_q == len_cur - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= 1'b1;
      cnt_q    <= '0;
      on_sh_q  <= '0;
      off_sh_q <= '0;
    end else if (!active_i) begin
      ph_q     <= 1'b1;
      cnt_q    <= '0;
      on_sh_q  <= on_len_i;
      off_sh_q <= off_len_i;
    end else if (last) begin
      ph_q     <= ~ph_q;
      cnt_q    <= '0;
      on_sh_q  <= on_len_i;
      off_sh_q <= off_len_i;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign wave_o = ph_q;
endmodule

// File: rtl/gbl_pinmux.sv
module gbl_pinmux
  import gbl_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]     out_i,
  input  logic [DW-1:0]     dir_i,
  input  logic [DW-1:0]     blink_i,
  input  logic [DW-1:0]     sel_i,
  input  logic [N_SETS-1:0] wave_i,
  output logic [N_SETS-1:0] act_o,
  output logic [DW-1:0]     pad_o,
  output logic [DW-1:0]     pad_oe_o
);
  assign act_o[0] = |(blink_i & ~sel_i);
  assign act_o[1] = |(blink_i & sel_i);

  for (genvar i = 0; i < DW; i++) begin : g_line
    assign pad_o[i]    = blink_i[i] ? wave_i[sel_i[i]] : out_i[i];
    assign pad_oe_o[i] = ~dir_i[i];
  end
endmodule

// File: rtl/gbl_blink_top.sv
module gbl_blink_top
  import gbl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] pad_oe_o
);
  localparam int unsigned CNT_W = DATA_W;

  logic [DATA_W-1:0]             out_q, dir_q, blink_q, sel_q;
  logic [N_SETS-1:0][DATA_W-1:0] on_q, off_q;
  logic [N_SETS-1:0]             act_w, wave_w;

  gbl_regs #(.DW(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .blink_q (blink_q),
    .sel_q   (sel_q),
    .on_q    (on_q),
    .off_q   (off_q)
  );

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    gbl_phase #(.CW(CNT_W)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (act_w[s]),
      .on_len_i  (on_q[s]),
      .off_len_i (off_q[s]),
      .wave_o    (wave_w[s])
    );
  end

  gbl_pinmux #(.DW(DATA_W)) u_mux (
    .out_i    (out_q),
    .dir_i    (dir_q),
    .blink_i  (blink_q),
    .sel_i    (sel_q),
    .wave_i   (wave_w),
    .act_o    (act_w),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );
endmodule

// File: rtl/gbl_blink_chk.sv
module gbl_blink_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [3:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] pad_o,
  input logic [DW-1:0] pad_oe_o,
  input logic [DW-1:0] out_q,
  input logic [DW-1:0] dir_q,
  input logic [DW-1:0] blink_q,
  input logic [1:0]    act_i,
  input logic [1:0]    wave_i
);
  a_r9_drive_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd9) |=>
      (((pad_oe_o & $past(wdata_i)) == $past(wdata_i)) &&
       ((pad_o & $past(wdata_i)) == $past(wdata_i))));

  a_r9_drive_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 4'd8) |=>
      (((pad_oe_o & $past(wdata_i)) == $past(wdata_i)) &&
       ((pad_o & $past(wdata_i)) == '0)));

  a_r11_input_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & dir_q) == '0);

  a_r3_static_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_o ^ out_q) & ~blink_q) == '0);

  a_r8_start_high_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_i[0]) |-> wave_i[0]);

  a_r8_start_high_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_i[1]) |-> wave_i[1]);
endmodule

bind gbl_blink_top gbl_blink_chk #(.DW(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .out_q    (out_q),
  .dir_q    (dir_q),
  .blink_q  (blink_q),
  .act_i    (act_w),
  .wave_i   (wave_w)
);

// File: tb/gbl_blink_top_tb_top.sv
`timescale 1ns/1ps
module gbl_blink_top_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          we;
  logic [3:0]    addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata, pad, oe;

  always #2 clk = ~clk;

  gbl_blink_top #(.DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pad_o       (pad),
    .pad_oe_o    (oe)
  );

  int total = 0;
  int bad   = 0;

  logic [DW-1:0] m_out, m_dir, m_blink, m_sel;
  int unsigned   m_on[2], m_off[2];

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      4'd0: m_out = d;
      4'd1: m_dir = d;
      4'd2: m_blink = d;
      4'd3: m_sel = d;
      4'd4: m_on[0] = d;
      4'd5: m_off[0] = d;
      4'd6: m_on[1] = d;
      4'd7: m_off[1] = d;
      4'd8: begin m_blink &= ~d; m_out &= ~d; m_dir &= ~d; end
      4'd9: begin m_blink &= ~d; m_out |= d; m_dir &= ~d; end
      default: ;
    endcase
  endtask

  task automatic rd(logic [3:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic wave_at(int k, int unsigned on, int unsigned off);
    int unsigned on_e, off_e;
    on_e  = (on == 0) ? 1 : on;
    off_e = (off == 0) ? 1 : off;
    return (k % (on_e + off_e)) < on_e;
  endfunction

  function automatic logic [DW-1:0] exp_pad(int k);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++)
      r[i] = m_blink[i] ? wave_at(k, m_on[m_sel[i]], m_off[m_sel[i]]) : m_out[i];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rv;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    m_out = '0; m_dir = '1; m_blink = '0; m_sel = '0;
    m_on = '{0, 0}; m_off = '{0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", oe, '0);
    chk("R1 pad", pad, '0);
    rd(4'd1, rv); chk("R1 dir", rv, '1);
    rd(4'd2, rv); chk("R1 blink", rv, '0);
    rd(4'd3, rv); chk("R1 sel", rv, '0);

    // R10 readback
    for (int a = 0; a < 8; a++) begin
      logic [DW-1:0] v;
      v = $urandom();
      if (a == 2) v = '0;
      wr(4'(a), v);
      rd(4'(a), rv); chk("R10 readback", rv, v);
    end
    rd(4'd8, rv); chk("R10 cmd lo reads 0", rv, '0);
    rd(4'd9, rv); chk("R10 cmd hi reads 0", rv, '0);
    wr(4'd2, '0);

    // R2, R3 static random
    for (int n = 0; n < 20; n++) begin
      wr(4'd0, $urandom());
      wr(4'd1, $urandom());
      chk("R3 static pad", pad, m_out);
      chk("R2 oe", oe, ~m_dir);
    end

    // R4, R5 directed: lines 0-3 set A, 4-7 set B
    wr(4'd4, 3); wr(4'd5, 2); wr(4'd6, 1); wr(4'd7, 4);
    wr(4'd3, 32'h0000_00F0); wr(4'd1, '0); wr(4'd0, 32'h0F0F_0F00);
    wr(4'd2, 32'h0000_00FF);
    for (int k = 0; k < 20; k++) begin
      chk("R4 R5 directed wave", pad, exp_pad(k));
      @(negedge clk);
    end
    wr(4'd2, '0);

    // R6 zero lengths
    wr(4'd4, 0); wr(4'd5, 0); wr(4'd3, '0); wr(4'd2, 32'h1);
    for (int k = 0; k < 8; k++) begin
      chk("R6 zero length", pad & 32'h1, {31'b0, (k % 2 == 0)});
      @(negedge clk);
    end
    wr(4'd2, '0);

    // R7 mid-phase change of on-length
    wr(4'd4, 4); wr(4'd5, 4); wr(4'd2, 32'h1);
    chk("R7 k0", pad & 32'h1, 32'h1);
    @(negedge clk);
    chk("R7 k1", pad & 32'h1, 32'h1);
    wr(4'd4, 2);
    for (int k = 3; k < 16; k++) begin
      logic e;
      e = (k < 4) ? 1'b1 : (k < 8) ? 1'b0 : wave_at(k - 8, 2, 4);
      chk("R7 boundary load", pad & 32'h1, {31'b0, e});
      @(negedge clk);
    end

    // R8 restart high after disable mid-low phase
    wr(4'd2, '0);
    wr(4'd2, 32'h1);
    chk("R8 restart high", pad & 32'h1, 32'h1);
    wr(4'd2, '0);

    // R11 input line with blink does not drive
    wr(4'd1, 32'h0000_0004); wr(4'd4, 1); wr(4'd5, 1); wr(4'd2, 32'h0000_0004);
    chk("R11 no drive", oe & 32'h4, '0);
    @(negedge clk);
    chk("R11 no drive later", oe & 32'h4, '0);

    // R9 drive commands
    wr(4'd2, 32'h0000_0018); wr(4'd1, 32'hFFFF_FFFF); wr(4'd0, 32'h0000_0000);
    wr(4'd9, 32'h0000_0028);
    rd(4'd2, rv); chk("R9 hi blink cleared", rv, 32'h0000_0010);
    chk("R9 hi oe", oe, ~m_dir);
    chk("R9 hi pad", pad & 32'h28, 32'h28);
    rd(4'd1, rv); chk("R9 hi dir", rv, 32'hFFFF_FFD7);
    wr(4'd8, 32'h0000_0020);
    chk("R9 lo pad", pad & 32'h28, 32'h08);
    rd(4'd0, rv); chk("R9 lo out", rv, 32'h0000_0008);
    wr(4'd2, '0);

    // R4 R5 random both sets
    for (int n = 0; n < 8; n++) begin
      wr(4'd4, $urandom_range(0, 5)); wr(4'd5, $urandom_range(0, 5));
      wr(4'd6, $urandom_range(0, 5)); wr(4'd7, $urandom_range(0, 5));
      wr(4'd3, $urandom()); wr(4'd0, $urandom()); wr(4'd1, $urandom());
      wr(4'd2, $urandom());
      for (int k = 0; k < 24; k++) begin
        chk("R4 R5 random wave", pad, exp_pad(k));
        chk("R2 random oe", oe, ~m_dir);
        @(negedge clk);
      end
      wr(4'd2, '0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule